// File: doc/BRIEF.md
# Linked-List Output Engine

This block feeds a peripheral from a linked list held in main memory. It takes command words from the head of an I/O command queue. Each command names a peripheral unit, an operation and the address of the first cell of a list. For the output operation the engine waits until the named unit is idle. It then follows the list's links through memory and copies each cell's two data fields, as one 30-bit word, into a 30-entry FIFO. The peripheral empties that FIFO through a valid/ready handshake.

A fill burst ends when the FIFO is full or when a cell with a zero link has been read. The engine keeps the address of the next unread cell as a resume pointer. When the FIFO drains to four words or fewer, it either restarts from that pointer or, if the list is finished, pops the command so that the next one can come up. Memory reads are destructive, so the list is consumed as it is sent. Commands with any other operation code are popped at once, with no transfer, and are flagged as unsupported.

Top module: `list_out_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid`, `memRd` and `cmdPop` are low.
- R2: A command word is split into marker bits [29:25], which are ignored, unit [24:18], operation [17:15] and list address [14:0]. `unitSel` shows the unit of the accepted command.
- R3: A command whose operation field is not 0 is popped in the cycle it is seen, with a one-cycle `cmdUnsup` pulse. It causes no memory read and no FIFO word.
- R4: After an output command (operation 0) is accepted, no memory read is issued while `unitBusy` is high for the selected unit.
- R5: The walk reads the cell at the list address first and then the cell named by each link. A memory cell is split into I [44:30], S [29:15] and link [14:0]. Each cell read pushes {I,S} into the FIFO, in list order, and each cell is read exactly once.
- R6: A fill burst stops when the FIFO holds 30 words. The FIFO never holds more than 30.
- R7: While a list is unfinished and the FIFO holds more than 4 words, no read is issued. When the FIFO falls to 4 words, reading resumes from the saved address and refills the FIFO to 30.
- R8: A burst ends after a cell with a zero link is read. The command is then popped once the FIFO holds 4 words or fewer, with no further read. A list address of 0 is an empty list and is popped with no read.
- R9: While `outValid` is high and `outReady` is low, `outData` is held. A word leaves the FIFO on each cycle in which both are high.
- R10: Each output command gives exactly one `cmdDone` pulse, together with `cmdPop`, and the following command is then decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | A command word is at the head of the queue |
| cmdWord | input | 30 | Command word at the head of the queue |
| cmdPop | output | 1 | Removes the head command |
| cmdDone | output | 1 | The popped command was a completed output |
| cmdUnsup | output | 1 | The popped command had an unsupported operation |
| unitSel | output | 7 | Unit number of the current command |
| unitBusy | input | 1 | The selected unit is busy |
| memRd | output | 1 | Memory read strobe |
| memAddr | output | 15 | Memory read address |
| memRdata | input | 45 | Read data, valid the cycle after `memRd` |
| outValid | output | 1 | The FIFO head word is valid |
| outData | output | 30 | FIFO head word |
| outReady | input | 1 | The peripheral takes the head word |

## Verification
List lengths are swept from 1 to 35 with a ready peripheral. This covers single-cell lists, lists that end before the FIFO fills and lists that need a refill, and the output stream is compared word by word each time. A 70-cell list with a stalled peripheral is then drained one word at a time. This shows that the burst stops at exactly 30 reads and that refill starts on the 26th removal and not one removal earlier. A held busy unit, an empty list, an unsupported operation and queued back-to-back commands with different marker bits separate the wait, the zero-address case, the reject path and the command sequencing.

// File: rtl/list_out_pkg.sv
package list_out_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAITU,
    ST_READ,
    ST_DATA,
    ST_HOLD
  } engState_t;

  typedef struct packed {
    logic ldCmd;
    logic memRd;
    logic push;
    logic advPtr;
    logic cmdPop;
    logic cmdDone;
    logic cmdUnsup;
  } engCtrl_t;

endpackage

// File: rtl/lo_fifo.sv
module lo_fifo #(
  parameter int W = 30,
  parameter int DEPTH = 30,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [W-1:0]     store [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic             popEff;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign popEff = pop && !empty;
  assign dout   = store[rdIdx];

  always_ff @(posedge clk) begin
    if (push) store[wrIdx] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (push) wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
      if (popEff) rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
      case ({push, popEff})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/lo_datapath.sv
module lo_datapath
  import list_out_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int UNIT_W = 7,
  parameter int OP_W = 3,
  parameter int MARK_W = 5,
  parameter int DEPTH = 30,
  parameter int LOW_MARK = 4,
  parameter int CMD_W = MARK_W + UNIT_W + OP_W + ADDR_W,
  parameter int CELL_W = 3 * ADDR_W,
  parameter int WORD_W = 2 * ADDR_W,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  engCtrl_t          c,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [CELL_W-1:0] memRdata,
  input  logic              outReady,
  output logic              opIsOut,
  output logic              ptrZero,
  output logic              linkZero,
  output logic              fifoFull,
  output logic              fifoLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic [UNIT_W-1:0] unitSel,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  output logic [CNT_W-1:0]  fifoCount
);
  localparam int OP_LSB = ADDR_W;
  localparam int UNIT_LSB = ADDR_W + OP_W;

  logic [ADDR_W-1:0] ptr;
  logic [UNIT_W-1:0] unitReg;
  logic              fifoEmpty;
  logic              unusedBits;

  assign unusedBits = ^{cmdWord[CMD_W-1 -: MARK_W], c.memRd, c.cmdPop, c.cmdDone, c.cmdUnsup};

  assign opIsOut  = (cmdWord[OP_LSB +: OP_W] == '0);
  assign ptrZero  = (ptr == '0);
  assign linkZero = (memRdata[ADDR_W-1:0] == '0);
  assign memAddr  = ptr;
  assign unitSel  = unitReg;
  assign fifoLow  = (fifoCount <= CNT_W'(LOW_MARK));
  assign outValid = !fifoEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      unitReg <= '0;
    end else begin
      if (c.ldCmd) begin
        ptr     <= cmdWord[ADDR_W-1:0];
        unitReg <= cmdWord[UNIT_LSB +: UNIT_W];
      end else if (c.advPtr) begin
        ptr <= memRdata[ADDR_W-1:0];
      end
    end
  end

  lo_fifo #(.W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) fifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (c.push),
    .din   (memRdata[CELL_W-1:ADDR_W]),
    .pop   (outReady),
    .dout  (outData),
    .count (fifoCount),
    .full  (fifoFull),
    .empty (fifoEmpty)
  );
endmodule

// File: rtl/lo_control.sv
module lo_control
  import list_out_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     opIsOut,
  input  logic     unitBusy,
  input  logic     ptrZero,
  input  logic     linkZero,
  input  logic     fifoFull,
  input  logic     fifoLow,
  output engCtrl_t c
);
  engState_t st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    c   = '0;
    case (st)
      ST_IDLE: begin
        if (cmdValid) begin
          if (opIsOut) begin
            c.ldCmd = 1'b1;
            nxt     = ST_WAITU;
          end else begin
            c.cmdPop   = 1'b1;
            c.cmdUnsup = 1'b1;
          end
        end
      end
      ST_WAITU: begin
        if (!unitBusy) nxt = ptrZero ? ST_HOLD : ST_READ;
      end
      ST_READ: begin
        if (fifoFull) begin
          nxt = ST_HOLD;
        end else begin
          c.memRd = 1'b1;
          nxt     = ST_DATA;
        end
      end
      ST_DATA: begin
        c.push   = 1'b1;
        c.advPtr = 1'b1;
        nxt      = linkZero ? ST_HOLD : ST_READ;
      end
      ST_HOLD: begin
        if (fifoLow) begin
          if (ptrZero) begin
            c.cmdPop  = 1'b1;
            c.cmdDone = 1'b1;
            nxt       = ST_IDLE;
          end else begin
            nxt = ST_READ;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/list_out_engine.sv
module list_out_engine
  import list_out_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int UNIT_W = 7,
  parameter int OP_W = 3,
  parameter int MARK_W = 5,
  parameter int DEPTH = 30,
  parameter int LOW_MARK = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   cmdValid,
  input  logic [MARK_W+UNIT_W+OP_W+ADDR_W-1:0]   cmdWord,
  output logic                                   cmdPop,
  output logic                                   cmdDone,
  output logic                                   cmdUnsup,
  output logic [UNIT_W-1:0]                      unitSel,
  input  logic                                   unitBusy,
  output logic                                   memRd,
  output logic [ADDR_W-1:0]                      memAddr,
  input  logic [3*ADDR_W-1:0]                    memRdata,
  output logic                                   outValid,
  output logic [2*ADDR_W-1:0]                    outData,
  input  logic                                   outReady
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  engCtrl_t         ctrl;
  logic             opIsOut, ptrZero, linkZero, fifoFull, fifoLow;
  logic [CNT_W-1:0] fifoCount;

  assign cmdPop   = ctrl.cmdPop;
  assign cmdDone  = ctrl.cmdDone;
  assign cmdUnsup = ctrl.cmdUnsup;
  assign memRd    = ctrl.memRd;

  lo_control ctl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .opIsOut  (opIsOut),
    .unitBusy (unitBusy),
    .ptrZero  (ptrZero),
    .linkZero (linkZero),
    .fifoFull (fifoFull),
    .fifoLow  (fifoLow),
    .c        (ctrl)
  );

  lo_datapath #(
    .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .OP_W(OP_W), .MARK_W(MARK_W),
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .CNT_W(CNT_W)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .c         (ctrl),
    .cmdWord   (cmdWord),
    .memRdata  (memRdata),
    .outReady  (outReady),
    .opIsOut   (opIsOut),
    .ptrZero   (ptrZero),
    .linkZero  (linkZero),
    .fifoFull  (fifoFull),
    .fifoLow   (fifoLow),
    .memAddr   (memAddr),
    .unitSel   (unitSel),
    .outValid  (outValid),
    .outData   (outData),
    .fifoCount (fifoCount)
  );
endmodule

// File: rtl/lo_checker.sv
module lo_checker
  import list_out_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DEPTH = 30,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input engCtrl_t          ctrl,
  input logic [CNT_W-1:0]  fifoCount,
  input logic [ADDR_W-1:0] memAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [2*ADDR_W-1:0] outData
);
  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.push |-> fifoCount < CNT_W'(DEPTH));

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R10
  pop_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.cmdDone || ctrl.cmdUnsup) |-> (ctrl.cmdPop && !(ctrl.cmdDone && ctrl.cmdUnsup)));

  // R3
  unsup_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cmdUnsup |-> !ctrl.memRd);

  // R5
  read_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memRd |-> memAddr != '0);
endmodule

bind list_out_engine lo_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrl      (ctrl),
  .fifoCount (fifoCount),
  .memAddr   (memAddr),
  .outValid  (outValid),
  .outReady  (outReady),
  .outData   (outData)
);

// File: tb/tb_list_out_engine.sv
`timescale 1ns/1ps
module tb_list_out_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid;
  logic [29:0] cmdWord;
  logic        cmdPop, cmdDone, cmdUnsup;
  logic [6:0]  unitSel;
  logic        unitBusy;
  logic        memRd;
  logic [14:0] memAddr;
  logic [44:0] memRdata;
  logic        outValid;
  logic [29:0] outData;
  logic        outReady = 1'b0;

  always #2 clk = ~clk;

  list_out_engine dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .cmdPop(cmdPop), .cmdDone(cmdDone), .cmdUnsup(cmdUnsup),
    .unitSel(unitSel), .unitBusy(unitBusy), .memRd(memRd), .memAddr(memAddr),
    .memRdata(memRdata), .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // memory model: registered read, destructive
  logic [44:0] mem [256];
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [44:0] wrData = '0;
  always @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (memRd) begin
      memRdata <= mem[memAddr[7:0]];
      mem[memAddr[7:0]] <= '0;
    end
  end

  // command queue model
  logic [29:0] q [64];
  int qLen = 0;
  int qIdx = 0;
  always @(posedge clk) if (cmdPop) qIdx <= qIdx + 1;
  assign cmdValid = (qIdx < qLen);
  assign cmdWord  = q[qIdx % 64];

  logic [127:0] busyVec = '0;
  assign unitBusy = busyVec[unitSel];

  logic [29:0] expQ [1024];
  int expWr = 0;
  int expRd = 0;
  int readCount = 0;
  int doneCount = 0;
  int unsupCount = 0;
  bit prevStall = 1'b0;
  logic [29:0] prevData;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor, sampling at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (memRd) readCount++;
      if (cmdDone) doneCount++;
      if (cmdUnsup) unsupCount++;
      if (prevStall) check(outValid && outData == prevData, "R9 held word", outData, prevData);
      if (outValid && outReady) begin
        check(expRd < expWr, "R5 unexpected word", expRd, expWr);
        check(outData == expQ[expRd % 1024], "R5 word value", outData, expQ[expRd % 1024]);
        expRd++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setCell(input int a, input logic [44:0] v);
    wrEn = 1'b1; wrAddr = 8'(a); wrData = v;
    tick(1);
    wrEn = 1'b0;
  endtask

  function automatic int cellAddr(input int i, input int base);
    return 1 + ((i * 37 + base) % 250);
  endfunction

  task automatic buildList(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      logic [14:0] iF, sF, lF;
      iF = 15'(i * 3 + len * 101 + 7);
      sF = 15'((i * 211) ^ (len * 5) ^ 'h155);
      lF = (i < len - 1) ? 15'(cellAddr(i + 1, base)) : 15'd0;
      setCell(cellAddr(i, base), {iF, sF, lF});
      expQ[expWr % 1024] = {iF, sF};
      expWr++;
    end
  endtask

  task automatic enqueue(input int mark, input int unit, input int op, input int addr);
    q[qLen % 64] = {5'(mark), 7'(unit), 3'(op), 15'(addr)};
    qLen++;
  endtask

  task automatic waitDone(input int target, input string tag);
    int t = 0;
    while ((doneCount < target || expRd < expWr) && t < 20000) begin
      tick(1);
      t++;
    end
    check(doneCount == target, tag, doneCount, target);
  endtask

  initial begin
    int r0, d0;
    busyVec = '0;
    tick(3);
    @(negedge clk);
    // R1 during reset
    check(!outValid && !memRd && !cmdPop, "R1 reset outputs", {outValid, memRd, cmdPop}, 0);
    tick(1);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !memRd && !cmdPop, "R1 after reset", {outValid, memRd, cmdPop}, 0);
    tick(1);

    // R3 unsupported operation
    enqueue(0, 3, 3, 20);
    tick(5);
    check(unsupCount == 1, "R3 unsupported pulse", unsupCount, 1);
    check(readCount == 0 && !outValid, "R3 no transfer", readCount, 0);
    check(qIdx == 1, "R3 popped", qIdx, 1);

    // R4 busy unit wait, R2 unit field, marker bits set
    outReady = 1'b1;
    buildList(5, 0);
    busyVec[9] = 1'b1;
    enqueue(31, 9, 0, cellAddr(0, 0));
    tick(20);
    check(readCount == 0, "R4 no read while busy", readCount, 0);
    check(unitSel == 7'd9, "R2 unit field", unitSel, 9);
    busyVec[9] = 1'b0;
    waitDone(1, "R10 done after short list");
    check(readCount == 5, "R5 cells read once", readCount, 5);
    check(unsupCount == 1, "R2 marker bits ignored", unsupCount, 1);
    for (int i = 0; i < 5; i++)
      check(mem[cellAddr(i, 0)] == '0, "R5 destructive read", 1, 0);

    // R6 and R7 long list with a stalled peripheral
    outReady = 1'b0;
    r0 = readCount;
    buildList(70, 3);
    enqueue(2, 4, 0, cellAddr(0, 3));
    tick(200);
    check(readCount - r0 == 30, "R6 burst stops at full", readCount - r0, 30);
    check(outValid, "R6 words waiting", outValid, 1);
    for (int p = 1; p <= 26; p++) begin
      outReady = 1'b1;
      tick(1);
      outReady = 1'b0;
      if (p < 26) begin
        tick(6);
        check(readCount - r0 == 30, "R7 no refill above mark", readCount - r0, 30);
      end else begin
        tick(90);
        check(readCount - r0 == 56, "R7 refill to full", readCount - r0, 56);
      end
    end
    outReady = 1'b1;
    waitDone(2, "R8 done after long list");
    check(readCount - r0 == 70, "R5 long list reads", readCount - r0, 70);

    // R8 empty list
    r0 = readCount;
    enqueue(0, 1, 0, 0);
    waitDone(3, "R8 empty list popped");
    check(readCount == r0, "R8 empty list no read", readCount, r0);

    // sweep of list lengths
    for (int len = 1; len <= 35; len++) begin
      d0 = doneCount;
      r0 = readCount;
      buildList(len, len);
      enqueue(len % 32, len % 128, 0, cellAddr(0, len));
      waitDone(d0 + 1, "R10 sweep done");
      check(readCount - r0 == len, "R8 stops at zero link", readCount - r0, len);
    end

    // back-to-back queue: unsupported, then two lists
    d0 = doneCount;
    buildList(3, 0);
    buildList(4, 5);
    enqueue(7, 2, 5, 100);
    enqueue(1, 2, 0, cellAddr(0, 0));
    enqueue(30, 6, 0, cellAddr(0, 5));
    waitDone(d0 + 2, "R10 queued commands");
    check(unsupCount == 2, "R3 queued unsupported", unsupCount, 2);
    check(expRd == expWr, "R5 all words delivered", expRd, expWr);

    tick(5);
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule